// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This purely combinational unit works on one field inside a data word. The field is given by the index of its lowest bit and by its width in bits. It supports three operations.

- **Unsigned extract** takes the field out of the source word and returns it right-aligned, with zeros above it.
- **Signed extract** does the same, but copies the field's top bit into every bit above it.
- **Insert** puts the low bits of the source word into the field position of a destination word. Every bit outside the field keeps its value from the destination.

Both extracts share one datapath. The field is first shifted left so that its top bit sits at the word's top. It is then shifted right, logically or arithmetically, by the word width minus the field width. Insert clears the field in the destination and then ORs the trimmed, shifted source into the gap. If a field does not fit in the word, the unit raises an error flag and returns the destination word unchanged.

Top module: `bitfield_unit`

## Requirements
- R1: With op = 2'b00 (unsigned extract), result bits [width-1:0] equal src_word[lsb+width-1:lsb], and every bit above them is 0.
- R2: With op = 2'b01 (signed extract), result bits [width-1:0] equal the field, and every bit above them equals src_word[lsb+width-1]. For example, lsb 4 and width 4 on 0x123456D8 give 0xFFFFFFFD.
- R3: With op = 2'b10 (insert), result bits [lsb+width-1:lsb] equal src_word[width-1:0], and every other bit equals the same bit of dst_word.
- R4: During insert, bits of src_word at or above index width have no effect on the result.
- R5: Width 32 at lsb 0 is legal. Both extracts then return src_word, and insert returns src_word.
- R6: The error flag bad_param is 1 exactly when width is 0, when width exceeds 32, or when lsb + width exceeds 32. It does not depend on op.
- R7: While bad_param is 1, result equals dst_word for every op.
- R8: With op = 2'b11 (reserved), result equals dst_word.
- R9: Inserting 0xA6 at lsb 8, width 8, into 0x80D635F0 gives 0x80D6A6F0. Only bits 15:8 change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_word | input | 32 | Word to extract from, or value to insert |
| dst_word | input | 32 | Destination word for insert; also the pass-through value |
| lsb_pos | input | 5 | Index of the field's lowest bit |
| fld_width | input | 6 | Field width in bits; 1 to 32 is legal |
| op | input | 2 | 00 unsigned extract, 01 signed extract, 10 insert, 11 reserved |
| result | output | 32 | Operation result |
| bad_param | output | 1 | Field does not fit in the word, or width is 0 |

## Verification
The assertions in the RTL are re-evaluated whenever an input changes. They cover the following:
- an unsigned extract leaves every bit above the field at zero;
- a signed extract fills those bits with copies of the field's top bit;
- an insert never disturbs a destination bit outside the field;
- an illegal field always passes the destination through.

The checks that need known numbers come from the bench's scenarios, which compare against a bit-by-bit model. These are:
- that the field contents arrive at the correct bit positions;
- that high source bits are ignored on insert;
- the full-width case;
- the worked examples with their exact values.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int W  = 32,
  parameter int PW = $clog2(W),
  parameter int WW = $clog2(W) + 1
) (
  input  logic [W-1:0]  src_word,
  input  logic [W-1:0]  dst_word,
  input  logic [PW-1:0] lsb_pos,
  input  logic [WW-1:0] fld_width,
  input  logic [1:0]    op,
  output logic [W-1:0]  result,
  output logic          bad_param
);
  localparam int TW = WW + 1;

  logic [TW-1:0] top_idx;
  logic [W-1:0]  low_ones, fld_mask, aligned, ext_u, ext_s, ins_val;
  logic [TW-1:0] lsh, rsh;

  assign top_idx   = TW'(lsb_pos) + TW'(fld_width);
  assign bad_param = (fld_width == '0) || (TW'(fld_width) > TW'(W)) || (top_idx > TW'(W));

  assign lsh      = bad_param ? '0 : TW'(W) - top_idx;
  assign rsh      = bad_param ? '0 : TW'(W) - TW'(fld_width);
  assign aligned  = src_word << lsh;
  assign ext_u    = aligned >> rsh;
  assign ext_s    = W'($signed(aligned) >>> rsh);

  assign low_ones = ~({W{1'b1}} << fld_width);
  assign fld_mask = low_ones << lsb_pos;
  assign ins_val  = (dst_word & ~fld_mask) | ((src_word & low_ones) << lsb_pos);

  always_comb begin
    if (bad_param) result = dst_word;
    else begin
      case (op)
        2'b00:   result = ext_u;
        2'b01:   result = ext_s;
        2'b10:   result = ins_val;
        default: result = dst_word;
      endcase
    end
  end

  always_comb begin
    if (!bad_param && op == 2'b00 && fld_width < WW'(W))
      a_r1_upper_zero: assert ((result >> fld_width) == '0);
    if (!bad_param && op == 2'b01)
      a_r2_sign_fill: assert ((result & ~low_ones) == (result[fld_width-1] ? ~low_ones : '0));
    if (!bad_param && op == 2'b10)
      a_r3_outside_kept: assert (((result ^ dst_word) & ~fld_mask) == '0);
    if (bad_param)
      a_r7_pass_dst: assert (result == dst_word);
  end
endmodule

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] src_word, dst_word, result;
  logic [4:0]  lsb_pos;
  logic [5:0]  fld_width;
  logic [1:0]  op;
  logic        bad_param;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  bitfield_unit u_bitfield_unit (.src_word(src_word), .dst_word(dst_word), .lsb_pos(lsb_pos),
    .fld_width(fld_width), .op(op), .result(result), .bad_param(bad_param));

  function automatic bit exp_bad(input int l, input int w);
    return (w == 0) || (w > 32) || (l + w > 32);
  endfunction

  function automatic logic [31:0] exp_res(input logic [1:0] o, input logic [31:0] s,
                                          input logic [31:0] d, input int l, input int w);
    logic [31:0] r;
    if (exp_bad(l, w)) return d;
    r = '0;
    case (o)
      2'b00: for (int i = 0; i < w; i++) r[i] = s[l+i];
      2'b01: begin
        for (int i = 0; i < w; i++) r[i] = s[l+i];
        for (int i = w; i < 32; i++) r[i] = s[l+w-1];
      end
      2'b10: begin
        r = d;
        for (int i = 0; i < w; i++) r[l+i] = s[i];
      end
      default: r = d;
    endcase
    return r;
  endfunction

  task automatic apply(input logic [1:0] o, input logic [31:0] s, input logic [31:0] d,
                       input int l, input int w);
    @(posedge clk);
    op = o; src_word = s; dst_word = d; lsb_pos = 5'(l); fld_width = 6'(w);
    @(negedge clk);
  endtask

  task automatic chk_res(input string tag, input logic [31:0] exp);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, exp);
    end
  endtask

  task automatic chk_flag(input string tag, input logic exp);
    n_run++;
    if (bad_param !== exp) begin
      n_fail++;
      $display("FAIL %s bad_param actual=%b expected=%b", tag, bad_param, exp);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] o, input logic [31:0] s,
                     input logic [31:0] d, input int l, input int w);
    apply(o, s, d, l, w);
    chk_res(tag, exp_res(o, s, d, l, w));
    chk_flag(tag, exp_bad(l, w));
  endtask

  initial begin
    void'($urandom(32'd1234));
    op = 2'b00; src_word = '0; dst_word = '0; lsb_pos = '0; fld_width = 6'd1;

    apply(2'b01, 32'h123456D8, 32'h0, 4, 4);
    chk_res("R2", 32'hFFFFFFFD);
    run("R1", 2'b00, 32'h123456D8, 32'h0, 4, 4);
    chk_res("R1", 32'h0000000D);
    run("R2", 2'b01, 32'h123456D8, 32'h0, 0, 4);
    run("R9", 2'b10, 32'h000000A6, 32'h80D635F0, 8, 8);
    chk_res("R9", 32'h80D6A6F0);
    run("R4", 2'b10, 32'hFFFFFF5A, 32'h00000000, 12, 8);
    chk_res("R4", 32'h0005A000);
    run("R5", 2'b00, 32'hDEADBEEF, 32'h1, 0, 32);
    chk_res("R5", 32'hDEADBEEF);
    run("R5", 2'b01, 32'hDEADBEEF, 32'h1, 0, 32);
    run("R5", 2'b10, 32'hDEADBEEF, 32'h1, 0, 32);
    chk_res("R5", 32'hDEADBEEF);
    run("R6", 2'b10, 32'h12345678, 32'hCAFEF00D, 1, 32);
    chk_flag("R6", 1'b1);
    run("R6", 2'b00, 32'h12345678, 32'hCAFEF00D, 0, 0);
    run("R6", 2'b01, 32'h12345678, 32'hCAFEF00D, 0, 33);
    run("R7", 2'b01, 32'h12345678, 32'hCAFEF00D, 31, 2);
    chk_res("R7", 32'hCAFEF00D);
    run("R6", 2'b00, 32'h80000000, 32'h0, 31, 1);
    chk_flag("R6", 1'b0);
    run("R2", 2'b01, 32'h80000000, 32'h0, 31, 1);
    run("R8", 2'b11, 32'h12345678, 32'h0BADBEEF, 4, 8);
    chk_res("R8", 32'h0BADBEEF);

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] o;
      int l, w;
      o = 2'($urandom_range(0, 3));
      l = $urandom_range(0, 31);
      w = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 40) : $urandom_range(1, 32 - l);
      case (o)
        2'b00: run("R1", o, $urandom, $urandom, l, w);
        2'b01: run("R2", o, $urandom, $urandom, l, w);
        2'b10: run("R3", o, $urandom, $urandom, l, w);
        default: run("R8", o, $urandom, $urandom, l, w);
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule